// File: doc/BRIEF.md
# Bit-Addressable General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port with a per-bit direction register and an output data latch. A small command bus can read a whole byte, write a whole byte, or set or clear one bit. Each pin is either an output, driving the level held in its latch bit, or an input, whose level passes through a synchroniser before any logic uses it.

Reading the data address returns a merged byte. Bits configured as inputs return the synchronised pin level. Bits configured as outputs return the latch contents. Set and clear commands are not per-bit writes. Each one runs a three-cycle sequence: it reads the merged byte, changes one bit, and writes the whole byte back into the latch. As a result, latch bits that belong to input pins are overwritten with the pin levels sampled during the read phase. The block reproduces this faithfully, so that software running against it sees the same hazard as on real hardware. Bit commands aimed at the direction address use the same sequence on the direction register.

Top module: `rmw_gpio_port`

## Requirements
- R1: After reset the direction register and the data latch are zero, so `pin_oe` and `pin_out` are 0x00 and `busy` is low.
- R2: A direction bit of 1 makes the pin an output: `pin_oe` equals the direction register, and `pin_out` carries the data latch.
- R3: A read of the data address (`cmd_sel`=0) returns the synchronised pin level for bits whose direction is 0 and the latch bit for bits whose direction is 1.
- R4: A byte write (`cmd_op`=2'b01) updates the selected register on the next clock edge without raising `busy`.
- R5: A bit-set command (`cmd_op`=2'b10) on the data address reads the merged byte, forces bit `cmd_bit` to 1 and writes the whole byte into the latch. Latch bits of input pins take the sampled pin levels: a latch of 0x80 with direction 0x3F and pins 0x40 becomes 0x41 after setting bit 0.
- R6: A bit-clear command (`cmd_op`=2'b11) follows the same read, modify and write-back sequence, but forces the selected bit to 0.
- R7: A bit command holds `busy` high for exactly three cycles after the edge that accepts it. Any byte read or byte write presented while `busy` is high is ignored, with no `rd_valid` and no register change.
- R8: Pin inputs pass through a two-flop synchroniser. A read accepted at the first or second edge after a pin change returns the old level. A read accepted at the third edge returns the new level.
- R9: A read of the direction address (`cmd_sel`=1) returns the stored direction byte. Changing the direction leaves the latch contents unchanged.
- R10: A byte read (`cmd_op`=2'b00) accepted at a clock edge raises `rd_valid` for exactly one cycle after that edge, with the result on `rd_data`.
- R11: A bit command on the direction address modifies only the selected direction bit, because that register reads back its own stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 write, 10 bit set, 11 bit clear |
| cmd_sel | input | 1 | Register select: 0 data latch, 1 direction |
| cmd_wdata | input | 8 | Byte write data |
| cmd_bit | input | 3 | Bit index for set and clear |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid, one cycle |
| busy | output | 1 | Bit command in progress, commands ignored |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Output drive levels |
| pin_oe | output | 8 | Output enables |

## Verification
The hardest situation to reach is a latch bit of an input pin that is silently overwritten. Seeing it requires three things: a latch value that differs from the pin level, a bit command issued long enough after the pin change that the synchroniser has settled, and a way to observe that latch bit afterwards. The bench first writes a latch byte whose input-pin bits differ from the driven pins. It then issues the bit command. Finally it turns every pin into an output so that a data read exposes the raw latch. A second sequence sends a byte write and then a byte read into the busy window, to show that both are dropped.

// File: rtl/rmw_gpio_pkg.sv
package rmw_gpio_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_BSET  = 2'b10,
      OP_BCLR  = 2'b11
   } gpio_op_e;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'b00,
      SEQ_READ   = 2'b01,
      SEQ_MODIFY = 2'b10,
      SEQ_WRITE  = 2'b11
   } seq_state_e;

   localparam logic SEL_DATA = 1'b0;
   localparam logic SEL_DIR  = 1'b1;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
   import rmw_gpio_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int BIT_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             set_i,
   input  logic [BIT_W-1:0] bit_i,
   input  logic             tgt_i,
   input  logic [WIDTH-1:0] rd_byte_i,
   output logic             busy_o,
   output logic             tgt_o,
   output logic             wr_en_o,
   output logic [WIDTH-1:0] wr_byte_o,
   output logic [BIT_W-1:0] wr_bit_o,
   output logic             wr_val_o
);

   seq_state_e       state_q;
   logic             set_q;
   logic             tgt_q;
   logic [BIT_W-1:0] bit_q;
   logic [WIDTH-1:0] work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         set_q   <= 1'b0;
         tgt_q   <= SEL_DATA;
         bit_q   <= '0;
         work_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (start_i) begin
               state_q <= SEQ_READ;
               set_q   <= set_i;
               tgt_q   <= tgt_i;
               bit_q   <= bit_i;
            end
            SEQ_READ: begin
               work_q  <= rd_byte_i;
               state_q <= SEQ_MODIFY;
            end
            SEQ_MODIFY: begin
               work_q[bit_q] <= set_q;
               state_q       <= SEQ_WRITE;
            end
            SEQ_WRITE: state_q <= SEQ_IDLE;
            default:   state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != SEQ_IDLE);
   assign tgt_o     = tgt_q;
   assign wr_en_o   = (state_q == SEQ_WRITE);
   assign wr_byte_o = work_q;
   assign wr_bit_o  = bit_q;
   assign wr_val_o  = set_q;

   // R7
   read_to_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_READ) |=> (state_q == SEQ_MODIFY));

   // R7
   write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_WRITE) |=> !busy_o);

   // R5
   modify_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_MODIFY) |=> (wr_en_o && wr_byte_o[bit_q] == set_q));

endmodule

// File: rtl/rmw_gpio_port.sv
module rmw_gpio_port
   import rmw_gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int BIT_W      = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic             cmd_sel,
   input  logic [WIDTH-1:0] cmd_wdata,
   input  logic [BIT_W-1:0] cmd_bit,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             busy,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("rmw_gpio_port: WIDTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] merged;
   logic [WIDTH-1:0] rmw_rd_byte;
   logic [WIDTH-1:0] rmw_wr_byte;
   logic [BIT_W-1:0] rmw_bit;
   logic             rmw_val;
   logic             rmw_tgt;
   logic             rmw_wr;
   logic             seq_busy;
   logic             accept, acc_rd, acc_wr, acc_bit;
   logic             rd_valid_q;
   logic [WIDTH-1:0] rd_data_q;

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (pin_sync)
   );

   assign merged      = (dir_q & latch_q) | (~dir_q & pin_sync);
   assign accept      = cmd_valid && !seq_busy;
   assign acc_rd      = accept && (cmd_op == OP_READ);
   assign acc_wr      = accept && (cmd_op == OP_WRITE);
   assign acc_bit     = accept && (cmd_op == OP_BSET || cmd_op == OP_BCLR);
   assign rmw_rd_byte = (rmw_tgt == SEL_DIR) ? dir_q : merged;

   gpio_rmw_seq #(.WIDTH(WIDTH)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (acc_bit),
      .set_i     (cmd_op == OP_BSET),
      .bit_i     (cmd_bit),
      .tgt_i     (cmd_sel),
      .rd_byte_i (rmw_rd_byte),
      .busy_o    (seq_busy),
      .tgt_o     (rmw_tgt),
      .wr_en_o   (rmw_wr),
      .wr_byte_o (rmw_wr_byte),
      .wr_bit_o  (rmw_bit),
      .wr_val_o  (rmw_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else if (rmw_wr) begin
         if (rmw_tgt == SEL_DIR) dir_q   <= rmw_wr_byte;
         else                    latch_q <= rmw_wr_byte;
      end else if (acc_wr) begin
         if (cmd_sel == SEL_DIR) dir_q   <= cmd_wdata;
         else                    latch_q <= cmd_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= acc_rd;
         if (acc_rd) rd_data_q <= (cmd_sel == SEL_DIR) ? dir_q : merged;
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;
   assign busy     = seq_busy;
   assign pin_out  = latch_q;
   assign pin_oe   = dir_q;

   // R4
   byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && cmd_sel == SEL_DATA) |=> (pin_out == $past(cmd_wdata) && !busy));

   // R9
   dir_write_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && cmd_sel == SEL_DIR) |=> $stable(pin_out));

   // R10
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> rd_valid);

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rmw_wr) |=> ($stable(pin_out) && $stable(pin_oe) && !rd_valid));

   // R5
   rmw_bit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rmw_wr && rmw_tgt == SEL_DATA) |=> (pin_out[$past(rmw_bit)] == $past(rmw_val)));

endmodule

// File: tb/rmw_gpio_port_tb_top.sv
module rmw_gpio_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic       cmd_sel = 1'b0;
   logic [7:0] cmd_wdata = 8'h00;
   logic [2:0] cmd_bit = 3'd0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       busy;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   rmw_gpio_port dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata), .cmd_bit(cmd_bit),
      .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // call at a negedge; returns at the next negedge
   task automatic issue(logic [1:0] op, logic sel, logic [7:0] data, logic [2:0] b);
      cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_wdata = data; cmd_bit = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic rd(logic sel, logic [7:0] exp, string req);
      exp_q.push_back(exp);
      tag_q.push_back(req);
      issue(2'b00, sel, 8'h00, 3'd0);
   endtask

   task automatic bitcmd(logic set, logic sel, logic [2:0] b);
      issue(set ? 2'b10 : 2'b11, sel, 8'h00, b);
      while (busy) @(negedge clk);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // monitor: pops expected read results as rd_valid appears
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7/R10 unexpected rd_valid actual=%02h expected=none", rd_data);
         end else begin
            string t;
            logic [7:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rd_data, e);
         end
      end
   end

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1 reset state
            check("R1 pin_oe", pin_oe, 8'h00);
            check("R1 pin_out", pin_out, 8'h00);
            check("R1 busy", {7'd0, busy}, 8'h00);
            check("R10 idle rd_valid", {7'd0, rd_valid}, 8'h00);
            rd(1'b1, 8'h00, "R9 dir after reset");
            rd(1'b0, 8'h00, "R3 data after reset");

            // R8 synchroniser latency (all pins inputs)
            pin_in = 8'hA5;
            rd(1'b0, 8'h00, "R8 first edge old level");
            rd(1'b0, 8'h00, "R8 second edge old level");
            rd(1'b0, 8'hA5, "R8 third edge new level");

            // R5 clobber scenario
            pin_in = 8'h40;
            issue(2'b01, 1'b1, 8'h3F, 3'd0);
            check("R2 pin_oe", pin_oe, 8'h3F);
            issue(2'b01, 1'b0, 8'h80, 3'd0);
            check("R4 byte write next edge", pin_out, 8'h80);
            check("R4 no busy", {7'd0, busy}, 8'h00);
            settle();
            rd(1'b0, 8'h40, "R3 merged read");
            bitcmd(1'b1, 1'b0, 3'd0);
            check("R5 latch after set", pin_out, 8'h41);
            check("R2 bit0 drives high", {7'd0, pin_out[0]}, 8'h01);
            rd(1'b0, 8'h41, "R5 merged after set");
            issue(2'b01, 1'b1, 8'hFF, 3'd0);
            check("R9 dir change keeps latch", pin_out, 8'h41);
            rd(1'b0, 8'h41, "R9 raw latch via read");
            rd(1'b1, 8'hFF, "R9 dir read");

            // R6 clear with clobber
            issue(2'b01, 1'b1, 8'h0F, 3'd0);
            pin_in = 8'hF0;
            settle();
            bitcmd(1'b0, 1'b0, 3'd0);
            check("R6 latch after clear", pin_out, 8'hF0);

            // R7 busy window, ignored commands
            issue(2'b01, 1'b1, 8'hFF, 3'd0);
            issue(2'b10, 1'b0, 8'h00, 3'd3);
            check("R7 busy cycle1", {7'd0, busy}, 8'h01);
            issue(2'b01, 1'b0, 8'h00, 3'd0);
            check("R7 busy cycle2", {7'd0, busy}, 8'h01);
            issue(2'b00, 1'b0, 8'h00, 3'd0);
            check("R7 busy cycle3", {7'd0, busy}, 8'h01);
            @(negedge clk);
            check("R7 busy ends", {7'd0, busy}, 8'h00);
            check("R7 write ignored", pin_out, 8'hF8);

            // R11 bit clear on direction
            bitcmd(1'b0, 1'b1, 3'd7);
            check("R11 pin_oe", pin_oe, 8'h7F);
            check("R11 latch untouched", pin_out, 8'hF8);
            rd(1'b1, 8'h7F, "R11 dir read");
            bitcmd(1'b1, 1'b1, 3'd7);
            rd(1'b1, 8'hFF, "R11 dir set back");
            repeat (3) @(negedge clk);
            check("R10 all reads returned", 8'(exp_q.size()), 8'h00);
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule